// File: doc/BRIEF.md
# Aligned Equal-Chunk Transfer Splitter

This block accepts one transfer request at a time. A request is a start address and a byte length. The block turns the request into a stream of segment descriptors, each an address and a length. Every segment fits a hardware count limit of 0x1FFF bytes.

Long requests are not cut greedily into maximum-size pieces. Before each segment, the block works out how many chunks the remaining length still needs. It then emits the remainder divided by that count, rounded down to a multiple of four. The pieces therefore come out nearly equal and aligned, and no short tail segment is left at the end. A request whose start address is not word aligned is refused, and so is a request of zero length. A refused request produces an error pulse and no segments.

The block uses a single restoring divider that produces one quotient bit per cycle. The chunk count is computed as a ceiling quotient, and the segment length is a second quotient. Both input and output use valid/ready handshakes.

The controller is a state machine with these states:
- IDLE accepts a request. On a refused request it goes to REJECT. If the length is at most 0x1FFF it goes to EMIT. Otherwise it goes to CEIL_GO.
- REJECT raises the error for one cycle and returns to IDLE.
- CEIL_GO starts the chunk-count divide and goes to CEIL_WAIT.
- CEIL_WAIT holds until the divide finishes and then goes to PART_GO.
- PART_GO starts the segment-length divide and goes to PART_WAIT.
- PART_WAIT holds until that divide finishes and then goes to EMIT.
- EMIT presents a segment. When the segment is taken, the next state depends on the new remainder. A remainder of zero returns to IDLE. A remainder of 0x1FFF or less stays in EMIT. A larger remainder goes back to CEIL_GO.

Top module: `seg_splitter`

## Requirements
- R1: After reset, req_ready is 1, seg_valid is 0, req_err is 0 and seg_count is 0.
- R2: A request accepted with req_addr[1:0] not equal to 0 makes req_err 1 for exactly one cycle, the cycle after acceptance. It produces no segment, and seg_count reads 0 afterwards.
- R3: A request accepted with req_len equal to 0 is refused in the same way as in R2.
- R4: A request with 1 <= req_len <= 0x1FFF yields exactly one segment. That segment has the request's address and full length, and seg_last is 1.
- R5: While the remaining length rem is above 0x1FFF, each segment length is floor(rem / ceil(rem / 0x1FFC)) with bits [1:0] cleared.
- R6: Each segment address equals the start address plus the sum of the earlier segment lengths. The segment lengths add up to req_len exactly.
- R7: Every segment length is nonzero and at most 0x1FFF. Every segment except the last has a length that is a multiple of 4.
- R8: seg_last is 1 only on the final segment. The cycle after the final segment is taken, seg_count equals the number of segments taken for the request.
- R9: req_ready is 0 from the acceptance of a request until its final segment is taken or its error pulse ends. It is 1 again the cycle after that.
- R10: While seg_valid is 1 and seg_ready is 0, seg_valid stays 1 and seg_addr and seg_len stay unchanged.
- R11: Each divide ends with a quotient q such that q*d <= n < (q+1)*d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Request start address |
| req_len | input | 32 | Request byte length |
| req_err | output | 1 | One-cycle pulse when a request is refused |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment taken by the consumer |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 32 | Segment byte length |
| seg_last | output | 1 | Final segment of the request |
| seg_count | output | 16 | Number of segments taken for the current request |

## Verification
The assertions check several rules on every cycle:
- the divider's quotient bounds;
- the limits on segment length and alignment;
- a held segment staying stable under backpressure;
- the input staying closed while a segment is offered;
- the error pulse never coinciding with a segment.

Only the bench's scenarios can show that the chunk lengths follow the equal-split formula and that the addresses advance correctly. The same holds for the lengths adding up to the request exactly, the segment count and last flag landing on the right segment, and refused requests producing nothing. The bench drives directed edge lengths around 0x1FFF and 0x1FFC multiples, then random aligned requests with random backpressure.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_CEIL_GO,
        ST_CEIL_WAIT,
        ST_PART_GO,
        ST_PART_WAIT,
        ST_EMIT
    } seg_state_t;
endpackage

// File: rtl/seg_req_check.sv
module seg_req_check #(
    parameter int LEN_W      = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ALIGN_BITS-1:0] addr_low,
    input  logic [LEN_W-1:0]      len,
    output logic                  bad
);
    always_comb begin
        bad = (addr_low != '0) || (len == '0);
    end
endmodule

// File: rtl/seg_divider.sv
module seg_divider #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]     acc;
    logic [W-1:0]   q;
    logic [W-1:0]   n_r;
    logic [W-1:0]   d_r;
    logic [CW-1:0]  cnt;
    logic           busy;
    logic [W:0]     shifted;
    logic [W:0]     diff;

    always_comb begin
        shifted = {acc[W-1:0], q[W-1]};
        diff    = shifted - {1'b0, d_r};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            q    <= '0;
            n_r  <= '0;
            d_r  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc  <= '0;
                q    <= dividend;
                n_r  <= dividend;
                d_r  <= divisor;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (!diff[W]) begin
                    acc <= diff;
                    q   <= {q[W-2:0], 1'b1};
                end else begin
                    acc <= shifted;
                    q   <= {q[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = q;

    logic [2*W-1:0] prod;
    logic [2*W-1:0] n_ext;
    logic [2*W-1:0] d_ext;
    always_comb begin
        prod  = {{W{1'b0}}, q} * {{W{1'b0}}, d_r};
        n_ext = {{W{1'b0}}, n_r};
        d_ext = {{W{1'b0}}, d_r};
    end

    assert_quot_bounds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod <= n_ext) && ((n_ext - prod) < d_ext));
endmodule

// File: rtl/seg_splitter.sv
module seg_splitter
    import seg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 32,
    parameter int MAX_SEG    = 'h1FFF,
    parameter int ALIGN_BITS = 2,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_err,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_last,
    output logic [CNT_W-1:0]  seg_count
);
    localparam int              DIV_W      = LEN_W + 1;
    localparam logic [LEN_W-1:0] ALIGN_MASK = LEN_W'((1 << ALIGN_BITS) - 1);
    localparam logic [LEN_W-1:0] MAX_LEN    = LEN_W'(MAX_SEG);
    localparam logic [LEN_W-1:0] CHUNK      = MAX_LEN & ~ALIGN_MASK;

    seg_state_t state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  cur_len;
    logic [DIV_W-1:0]  mult_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  rem_after;
    logic              req_bad;
    logic              div_start;
    logic              div_done;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  part_len;

    seg_req_check #(.LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)) u_check (
        .addr_low (req_addr[ALIGN_BITS-1:0]),
        .len      (req_len),
        .bad      (req_bad)
    );

    seg_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .done     (div_done),
        .quotient (div_q)
    );

    always_comb begin
        rem_after = rem_q - cur_len;
        part_len  = div_q & ~{{(DIV_W-LEN_W){1'b0}}, ALIGN_MASK};
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_bad)                state_d = ST_REJECT;
                    else if (req_len <= MAX_LEN) state_d = ST_EMIT;
                    else                        state_d = ST_CEIL_GO;
                end
            end
            ST_REJECT:    state_d = ST_IDLE;
            ST_CEIL_GO:   state_d = ST_CEIL_WAIT;
            ST_CEIL_WAIT: if (div_done) state_d = ST_PART_GO;
            ST_PART_GO:   state_d = ST_PART_WAIT;
            ST_PART_WAIT: if (div_done) state_d = ST_EMIT;
            ST_EMIT: begin
                if (seg_ready) begin
                    if (rem_after == '0)           state_d = ST_IDLE;
                    else if (rem_after <= MAX_LEN) state_d = ST_EMIT;
                    else                           state_d = ST_CEIL_GO;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        req_err   = (state_q == ST_REJECT);
        seg_valid = (state_q == ST_EMIT);
        div_start = (state_q == ST_CEIL_GO) || (state_q == ST_PART_GO);
        if (state_q == ST_PART_GO) begin
            div_num = {1'b0, rem_q};
            div_den = mult_q;
        end else begin
            div_num = {1'b0, rem_q} + DIV_W'(CHUNK - LEN_W'(1));
            div_den = {1'b0, CHUNK};
        end
        seg_addr  = addr_q;
        seg_len   = cur_len;
        seg_last  = (cur_len == rem_q);
        seg_count = cnt_q;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            cur_len <= '0;
            mult_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                rem_q   <= req_len;
                cur_len <= req_len;
                cnt_q   <= '0;
            end
            if (state_q == ST_CEIL_WAIT && div_done) mult_q <= div_q;
            if (state_q == ST_PART_WAIT && div_done) cur_len <= part_len[LEN_W-1:0];
            if (state_q == ST_EMIT && seg_ready) begin
                addr_q  <= addr_q + ADDR_W'(cur_len);
                rem_q   <= rem_after;
                cur_len <= rem_after;
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end
    end

    assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0) && (seg_len <= MAX_LEN));
    assert_len_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_last) |-> ((seg_len & ALIGN_MASK) == '0));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> seg_valid && $stable(seg_addr) && $stable(seg_len));
    assert_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !req_ready);
    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !seg_valid && !req_ready);
    assert_part_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PART_WAIT && div_done) |-> (div_q[DIV_W-1] == 1'b0));
endmodule

// File: tb/seg_splitter_bench.sv
`timescale 1ns/1ps
module seg_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [31:0] req_len;
    logic        req_err;
    logic        seg_valid;
    logic        seg_ready;
    logic [31:0] seg_addr;
    logic [31:0] seg_len;
    logic        seg_last;
    logic [15:0] seg_count;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    seg_splitter u_seg_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
        .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .seg_count(seg_count)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_len(input logic [31:0] rem);
        longint unsigned mult;
        if (rem <= 32'h1FFF) return rem;
        mult = (longint'(rem) + 64'h1FFB) / 64'h1FFC;
        return 32'((longint'(rem) / mult) & ~64'h3);
    endfunction

    task automatic run_req(input logic [31:0] a, input logic [31:0] l, input int backp);
        bit          bad;
        bit          done;
        int          n;
        int          guard;
        logic [31:0] exp_addr;
        logic [31:0] exp_rem;
        logic [31:0] el;
        longint      sum;
        bad = (a[1:0] != 2'b00) || (l == 32'd0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = l;
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            check(req_err == 1'b1, (l == 0) ? "R3 err pulse" : "R2 err pulse", req_err, 1);
            check(seg_valid == 1'b0, "R2 no segment", seg_valid, 0);
            @(negedge clk);
            check(req_err == 1'b0, "R2 err one cycle", req_err, 0);
            check(req_ready == 1'b1 && seg_valid == 1'b0, "R9 reopen after reject", req_ready, 1);
            check(seg_count == 16'd0, "R3 count zero", seg_count, 0);
            return;
        end
        check(req_err == 1'b0, "R2 no err on good", req_err, 0);
        check(req_ready == 1'b0, "R9 closed after accept", req_ready, 0);
        exp_addr = a;
        exp_rem  = l;
        n = 0; guard = 0; done = 0; sum = 0;
        while (!done && guard < 40000) begin
            guard++;
            seg_ready = (($urandom % 100) >= backp);
            #0.1;
            if (seg_valid) check(req_ready == 1'b0, "R9 closed while busy", req_ready, 0);
            if (seg_valid && seg_ready) begin
                el = next_len(exp_rem);
                check(seg_addr == exp_addr, "R6 address", seg_addr, exp_addr);
                if (l <= 32'h1FFF) check(seg_len == el, "R4 single length", seg_len, el);
                else               check(seg_len == el, "R5 R11 chunk length", seg_len, el);
                check(seg_last == (el == exp_rem), "R8 last flag", seg_last, (el == exp_rem));
                check(seg_len != 0 && seg_len <= 32'h1FFF &&
                      (seg_last || seg_len[1:0] == 2'b00), "R7 length bound", seg_len, el);
                sum += seg_len;
                exp_addr = exp_addr + el;
                exp_rem  = exp_rem - el;
                n++;
                if (exp_rem == 0) done = 1;
            end
            @(negedge clk);
        end
        seg_ready = 1'b0;
        check(done, "R9 request finished", done, 1);
        check(sum == longint'(l), "R6 length sum", sum, l);
        check(seg_count == 16'(n), "R8 segment count", seg_count, n);
        if (l <= 32'h1FFF) check(n == 1, "R4 one segment", n, 1);
        check(req_ready == 1'b1 && seg_valid == 1'b0, "R9 reopen", req_ready, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; seg_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(seg_valid == 1'b0, "R1 valid", seg_valid, 0);
        check(req_err == 1'b0, "R1 err", req_err, 0);
        check(seg_count == 16'd0, "R1 count", seg_count, 0);

        run_req(32'h0000_1000, 32'd4, 0);
        run_req(32'h0000_2000, 32'h1FFF, 30);
        run_req(32'h0000_0004, 32'h2000, 0);
        run_req(32'h0000_0008, 32'h1FFD, 50);
        run_req(32'h0010_0000, 32'h1FFC * 3, 20);
        run_req(32'h0010_0000, 32'h1FFC * 3 + 1, 20);
        run_req(32'h0000_0100, 32'h10000, 40);
        run_req(32'hFFFF_F000, 32'h4003, 10);
        run_req(32'h0000_0002, 32'h100, 0);
        run_req(32'h0000_0001, 32'h3000, 0);
        run_req(32'h0000_0040, 32'd0, 0);
        for (int i = 0; i < 25; i++) begin
            logic [31:0] ra;
            logic [31:0] rl;
            ra = {$urandom, 2'b00} >> 0;
            ra[1:0] = 2'b00;
            if (($urandom % 8) == 0) ra[1:0] = 2'(1 + $urandom % 3);
            rl = 32'(1 + ($urandom % 32'h30000));
            run_req(ra, rl, int'($urandom % 60));
        end
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule